// File: doc/BRIEF.md
# Gated 16-bit Event Timer

This block is a 16-bit up-counter that counts the edges of an external timer clock. The counter is not clocked by that signal. The block samples the selected timer-clock input on its own system clock. It can pass the input through a two-flop synchronizer first or use it directly, and it counts the rising edges it detects. A two-bit prescaler divides those edges by 1, 2, 4 or 8 before they reach the counter. An optional gate can hold the count. The gate is chosen from four gate inputs, and a polarity control picks which gate level lets counting proceed.

Software reaches the block through a byte-wide register port with four addresses. Two of those addresses access the low and high halves of the counter. An atomic mode lets a 16-bit value be read or written consistently. In this mode, reading the low byte captures the high byte into a shadow register. A high-byte write is held until the next low-byte write, and both halves are then loaded together.

When the counter wraps from 0xFFFF to 0x0000, the block drives a one-cycle pulse and sets a sticky overflow flag. When the gate goes from active to inactive, the block sets a sticky gate-event flag. Software clears either flag by writing 1 to its bit. After every enable, counting starts only once a falling edge of the timer clock has been seen.

Top module: `gtimer16`

## Requirements
- R1: While enabled, armed and not gated off, each rising edge of the selected timer clock (`tclkSrc[clkSel]`, sampled through the two-flop path when control bit 3 is 1) advances the prescaler. With ratio 1:1, each such edge increments the counter by one. The counter never changes by more than one per system cycle unless it is written.
- R2: When control bit 0 (enable) is 0, the counter holds and the block is disarmed. After enable, a rising edge that comes before the first falling edge is not counted.
- R3: Control bits [2:1] select the prescaler ratio: 00 gives 1:1, 01 gives 1:2, 10 gives 1:4 and 11 gives 1:8. The counter increments on every N-th counted rising edge.
- R4: With control bit 4 (atomic mode) set, a read of the low-count register (address 2) copies the live high byte into a shadow. A read of address 3 then returns that shadow. A write to address 3 changes nothing until the next write to address 2, which loads the held high byte and the new low byte together.
- R5: With atomic mode clear, addresses 2 and 3 read and write the live low and high counter bytes directly. Any counter write also clears the prescaler count.
- R6: When a counted increment takes the counter from 0xFFFF to 0x0000, `rollPulse` is high for exactly one system cycle and the overflow flag (status bit 3, also `ovfFlag`) is set.
- R7: When control bit 5 (gate enable) is 1, counting proceeds only while the gate is active. The gate is selected by status bits [1:0], and its level is inverted when control bit 6 is 1, so that 0 means active-high. Status bit 2 always shows the current active state of the gate.
- R8: While gate enable is set, a change of the gate from active to inactive sets the gate-event flag (status bit 4, also `gateFlag`).
- R9: Both flags stay set until software writes 1 to their status bit. Writing 0 leaves them set. A new set event in the same cycle as a clear takes priority.
- R10: After reset, every register reads 0: control, status and both counter bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tclkSrc | input | 2 | Candidate timer-clock inputs; status bit 5 selects one |
| gateIn | input | 4 | Candidate gate inputs |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (needed for shadow capture) |
| addr | input | 2 | Register address: 0 control, 1 status, 2 count low, 3 count high |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` |
| rollPulse | output | 1 | One-cycle pulse on rollover |
| ovfFlag | output | 1 | Sticky overflow flag |
| gateFlag | output | 1 | Sticky gate-event flag |

## Verification
Some properties are checked on every cycle: the counter steps by at most one, it holds while disabled or gated off, the rollover pulse lasts one cycle and coincides with a zero count, and the overflow and gate-event flags rise after their events. Other behaviour needs ordered stimulus, so only the bench scenarios show it. This covers the falling-edge arming after enable, the exact prescaler ratios, the prescaler clear on a counter write, the shadow-byte and held-write ordering of atomic mode, and write-one-to-clear.

// File: rtl/gtimer16_pkg.sv
package gtimer16_pkg;
  localparam int CNT_W      = 16;
  localparam int BYTE_W     = 8;
  localparam int PS_W       = 2;
  localparam int PSC_W      = (1 << PS_W) - 1;
  localparam int GSEL_W     = 2;
  localparam int NUM_GATE   = 1 << GSEL_W;
  localparam int NUM_CLK    = 2;
  localparam int CSEL_W     = $clog2(NUM_CLK);
  localparam int SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_CLO  = 2'd2,
    A_CHI  = 2'd3
  } regAddr_t;

  // Strobes and settings from control to datapath
  typedef struct packed {
    logic              enable;
    logic              syncMode;
    logic [PS_W-1:0]   psSel;
    logic              gateOpen;
    logic              loadLo;
    logic              loadHi;
    logic [BYTE_W-1:0] loadLoVal;
    logic [BYTE_W-1:0] loadHiVal;
  } dpCtl_t;
endpackage

// File: rtl/gtimer16_dp.sv
module gtimer16_dp
  import gtimer16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tclkIn,
  input  dpCtl_t           ctl,
  output logic [CNT_W-1:0] cnt,
  output logic             rollPulse
);
  logic [SYNC_DEPTH-1:0] syncQ;
  logic tclkSmp, prevT, riseT, fallT, armed, countEdge, anyLoad, psHit;
  logic [PSC_W-1:0] psCnt, psLimit;
  logic [CNT_W-1:0] cntQ;

  // Sampling path: the synchronizer chain or the raw input
  generate
    if (SYNC_DEPTH > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) syncQ <= '0;
        else        syncQ <= {syncQ[SYNC_DEPTH-2:0], tclkIn};
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) syncQ <= '0;
        else        syncQ <= tclkIn;
    end
  endgenerate

  assign tclkSmp = ctl.syncMode ? syncQ[SYNC_DEPTH-1] : tclkIn;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prevT <= 1'b0;
    else        prevT <= tclkSmp;

  assign riseT = tclkSmp & ~prevT;
  assign fallT = ~tclkSmp & prevT;

  // Arming: a falling edge must follow each enable
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           armed <= 1'b0;
    else if (!ctl.enable) armed <= 1'b0;
    else if (fallT)       armed <= 1'b1;

  always_comb psLimit = PSC_W'((1 << ctl.psSel) - 1);

  assign countEdge = riseT & armed & ctl.enable & ctl.gateOpen;
  assign psHit     = (psCnt >= psLimit);
  assign anyLoad   = ctl.loadLo | ctl.loadHi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psCnt     <= '0;
      cntQ      <= '0;
      rollPulse <= 1'b0;
    end else if (anyLoad) begin
      psCnt     <= '0;
      rollPulse <= 1'b0;
      if (ctl.loadLo) cntQ[BYTE_W-1:0]     <= ctl.loadLoVal;
      if (ctl.loadHi) cntQ[CNT_W-1:BYTE_W] <= ctl.loadHiVal;
    end else if (countEdge) begin
      if (psHit) begin
        psCnt     <= '0;
        cntQ      <= cntQ + 1'b1;
        rollPulse <= &cntQ;
      end else begin
        psCnt     <= psCnt + 1'b1;
        rollPulse <= 1'b0;
      end
    end else begin
      rollPulse <= 1'b0;
    end
  end

  assign cnt = cntQ;
endmodule

// File: rtl/gtimer16_ctrl.sv
module gtimer16_ctrl
  import gtimer16_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [1:0]          addr,
  input  logic [BYTE_W-1:0]   wrData,
  output logic [BYTE_W-1:0]   rdData,
  input  logic [NUM_GATE-1:0] gateIn,
  input  logic [CNT_W-1:0]    cnt,
  input  logic                rollPulse,
  output dpCtl_t              ctl,
  output logic [CSEL_W-1:0]   clkSel,
  output logic                ovfFlag,
  output logic                gateFlag,
  output logic                gateActive,
  output logic                gateEn
);
  logic [6:0]        ctrlQ;
  logic [GSEL_W-1:0] gateSel;
  logic [BYTE_W-1:0] hiBuf, shadowHi;
  logic              gateLvlQ, gateActPrev, atomic, gatePol;
  logic              wrCtrl, wrStat, wrLo, wrHi, rdLo;
  regAddr_t          addrE;

  assign addrE   = regAddr_t'(addr);
  assign wrCtrl  = wrEn && addrE == A_CTRL;
  assign wrStat  = wrEn && addrE == A_STAT;
  assign wrLo    = wrEn && addrE == A_CLO;
  assign wrHi    = wrEn && addrE == A_CHI;
  assign rdLo    = rdEn && addrE == A_CLO;
  assign atomic  = ctrlQ[4];
  assign gateEn  = ctrlQ[5];
  assign gatePol = ctrlQ[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlQ    <= '0;
      gateSel  <= '0;
      clkSel   <= '0;
      hiBuf    <= '0;
      shadowHi <= '0;
    end else begin
      if (wrCtrl) ctrlQ <= wrData[6:0];
      if (wrStat) begin
        gateSel <= wrData[GSEL_W-1:0];
        clkSel  <= wrData[5 +: CSEL_W];
      end
      if (wrHi && atomic) hiBuf <= wrData;
      if (rdLo) shadowHi <= cnt[CNT_W-1:BYTE_W];
    end
  end

  // Gate level sampling and event detection
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gateLvlQ    <= 1'b0;
      gateActPrev <= 1'b0;
    end else begin
      gateLvlQ    <= gateIn[gateSel];
      gateActPrev <= gateActive;
    end

  assign gateActive = gateLvlQ ^ gatePol;

  // Sticky flags: set wins over write-one-to-clear
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ovfFlag  <= 1'b0;
      gateFlag <= 1'b0;
    end else begin
      ovfFlag  <= (ovfFlag  & ~(wrStat & wrData[3])) | rollPulse;
      gateFlag <= (gateFlag & ~(wrStat & wrData[4])) |
                  (gateEn & gateActPrev & ~gateActive);
    end

  always_comb begin
    ctl.enable    = ctrlQ[0];
    ctl.psSel     = ctrlQ[2:1];
    ctl.syncMode  = ctrlQ[3];
    ctl.gateOpen  = ~gateEn | gateActive;
    ctl.loadLo    = wrLo;
    ctl.loadLoVal = wrData;
    ctl.loadHi    = atomic ? wrLo : wrHi;
    ctl.loadHiVal = atomic ? hiBuf : wrData;
  end

  always_comb begin
    unique case (addrE)
      A_CTRL:  rdData = {1'b0, ctrlQ};
      A_STAT:  rdData = {{(3-CSEL_W){1'b0}}, clkSel, gateFlag, ovfFlag,
                         gateActive, gateSel};
      A_CLO:   rdData = cnt[BYTE_W-1:0];
      default: rdData = atomic ? shadowHi : cnt[CNT_W-1:BYTE_W];
    endcase
  end
endmodule

// File: rtl/gtimer16.sv
module gtimer16
  import gtimer16_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CLK-1:0]  tclkSrc,
  input  logic [NUM_GATE-1:0] gateIn,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [1:0]          addr,
  input  logic [BYTE_W-1:0]   wrData,
  output logic [BYTE_W-1:0]   rdData,
  output logic                rollPulse,
  output logic                ovfFlag,
  output logic                gateFlag
);
  dpCtl_t            dpCtl;
  logic [CNT_W-1:0]  cntVal;
  logic [CSEL_W-1:0] clkSel;
  logic              gateActive, gateEn, tclkIn;

  assign tclkIn = tclkSrc[clkSel];

  gtimer16_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .gateIn(gateIn), .cnt(cntVal),
    .rollPulse(rollPulse), .ctl(dpCtl), .clkSel(clkSel),
    .ovfFlag(ovfFlag), .gateFlag(gateFlag), .gateActive(gateActive),
    .gateEn(gateEn)
  );

  gtimer16_dp u_dp (
    .clk(clk), .rst_n(rst_n), .tclkIn(tclkIn), .ctl(dpCtl),
    .cnt(cntVal), .rollPulse(rollPulse)
  );
endmodule

// File: rtl/gtimer16_chk.sv
module gtimer16_chk
  import gtimer16_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cntVal,
  input logic             rollPulse,
  input logic             ovfFlag,
  input logic             gateFlag,
  input logic             gateActive,
  input logic             gateEn,
  input dpCtl_t           dpCtl
);
  logic anyLoad;
  assign anyLoad = dpCtl.loadLo | dpCtl.loadHi;

  p_step_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !anyLoad |=> (cntVal == $past(cntVal) || cntVal == $past(cntVal) + 1'b1));

  p_hold_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dpCtl.enable && !anyLoad) |=> cntVal == $past(cntVal));

  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rollPulse |=> !rollPulse);

  p_pulse_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rollPulse |-> cntVal == '0);

  p_ovf_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rollPulse |=> ovfFlag);

  p_gate_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gateEn && !gateActive && !anyLoad) |=> cntVal == $past(cntVal));

  p_gate_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gateEn && $fell(gateActive)) |=> gateFlag);
endmodule

bind gtimer16 gtimer16_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cntVal(cntVal), .rollPulse(rollPulse),
  .ovfFlag(ovfFlag), .gateFlag(gateFlag), .gateActive(gateActive),
  .gateEn(gateEn), .dpCtl(dpCtl)
);

// File: tb/gtimer16_tb.sv
module gtimer16_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_TCLK  = 6;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] tclkSrc = '0;
  logic [3:0] gateIn = '0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       rollPulse, ovfFlag, gateFlag;

  int compared = 0, mismatched = 0, pulseCnt = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sbQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gtimer16 u_dut (
    .clk(clk), .rst_n(rst_n), .tclkSrc(tclkSrc), .gateIn(gateIn),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rollPulse(rollPulse), .ovfFlag(ovfFlag),
    .gateFlag(gateFlag)
  );

  // Monitor: compares each read against the queued expectation
  always @(negedge clk) begin
    if (rollPulse) pulseCnt++;
    if (rdEn) begin
      item_t it;
      compared++;
      if (sbQ.size() == 0) begin
        mismatched++;
        $display("FAIL scoreboard: read with empty queue, got %h expected none", rdData);
      end else begin
        it = sbQ.pop_front();
        if (rdData !== it.exp) begin
          mismatched++;
          $display("FAIL %s: rdData=%h expected=%h", it.tag, rdData, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    @(posedge clk); #1;
    sbQ.push_back(it);
    rdEn = 1'b1; addr = a;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic setT(input logic v);
    tclkSrc[0] = v;
    repeat (HALF_TCLK) @(posedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      setT(1'b1);
      setT(1'b0);
    end
  endtask

  task automatic checkVal(input int act, input int exp, input string tag);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state
    rd(2'd0, 8'h00, "R10 ctrl");
    rd(2'd1, 8'h00, "R10 status");
    rd(2'd2, 8'h00, "R10 count low");
    rd(2'd3, 8'h00, "R10 count high");

    // R1/R2: enable, unarmed rise ignored, then five counted rises
    wr(2'd0, 8'h09);
    pulses(1);
    pulses(5);
    rd(2'd2, 8'h05, "R2 first rise before fall not counted, R1 count");
    rd(2'd3, 8'h00, "R1 high byte");

    // R3 prescaler ratios
    wr(2'd0, 8'h0D); wr(2'd2, 8'h00); pulses(8);
    rd(2'd2, 8'h02, "R3 ratio 1:4");
    wr(2'd0, 8'h0F); wr(2'd2, 8'h00); pulses(19);
    rd(2'd2, 8'h02, "R3 ratio 1:8");
    wr(2'd0, 8'h0B); wr(2'd2, 8'h00); pulses(5);
    rd(2'd2, 8'h02, "R3 ratio 1:2");

    // R5 direct byte access and prescaler clear on write
    wr(2'd3, 8'hAB);
    rd(2'd3, 8'hAB, "R5 direct high write");
    rd(2'd2, 8'h02, "R5 low unchanged");
    pulses(1);
    wr(2'd2, 8'h10);
    pulses(1);
    rd(2'd2, 8'h10, "R5 prescaler cleared by write");

    // R4 atomic access
    wr(2'd0, 8'h18);
    wr(2'd3, 8'h12); wr(2'd2, 8'h34);
    rd(2'd2, 8'h34, "R4 atomic low");
    wr(2'd3, 8'h56); wr(2'd2, 8'h78);
    rd(2'd3, 8'h12, "R4 high returns shadow");
    rd(2'd2, 8'h78, "R4 paired load low");
    wr(2'd3, 8'h9A);
    rd(2'd2, 8'h78, "R4 held high write");
    rd(2'd3, 8'h56, "R4 high not applied before low write");

    // R6 rollover
    wr(2'd0, 8'h08);
    wr(2'd3, 8'hFF); wr(2'd2, 8'hFE);
    pulseCnt = 0;
    wr(2'd0, 8'h09);
    pulses(1);
    pulses(1);
    rd(2'd2, 8'hFF, "R6 at FFFF low");
    rd(2'd3, 8'hFF, "R6 at FFFF high");
    checkVal(pulseCnt, 0, "R6 no pulse before wrap");
    pulses(1);
    rd(2'd2, 8'h00, "R6 wrapped low");
    rd(2'd3, 8'h00, "R6 wrapped high");
    checkVal(pulseCnt, 1, "R6 single pulse cycle");
    rd(2'd1, 8'h08, "R6 overflow flag set");

    // R9 sticky flags, write-one-to-clear
    wr(2'd1, 8'h00);
    rd(2'd1, 8'h08, "R9 write 0 keeps flag");
    wr(2'd1, 8'h08);
    rd(2'd1, 8'h00, "R9 write 1 clears flag");

    // R7/R8 gating
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h29);
    wr(2'd2, 8'h00);
    pulses(3);
    rd(2'd2, 8'h00, "R7 gate inactive blocks count");
    rd(2'd1, 8'h02, "R7 gate value low");
    gateIn[2] = 1'b1;
    repeat (4) @(posedge clk);
    rd(2'd1, 8'h06, "R7 gate value active");
    pulses(3);
    rd(2'd2, 8'h03, "R7 gate active counts");
    gateIn[2] = 1'b0;
    repeat (4) @(posedge clk);
    rd(2'd1, 8'h12, "R8 gate event flag");
    pulses(2);
    rd(2'd2, 8'h03, "R7 gate closed again");
    wr(2'd0, 8'h69);
    repeat (4) @(posedge clk);
    rd(2'd1, 8'h16, "R7 inverted polarity active when low");
    pulses(2);
    rd(2'd2, 8'h05, "R7 inverted polarity counts");
    wr(2'd1, 8'h12);
    rd(2'd1, 8'h06, "R9 gate flag cleared");

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule